// File: doc/BRIEF.md
# Dual-Select Serial Register and FIFO Slave Port

This block is the serial slave that a host microcontroller uses to configure a radio transmitter controller and to feed it payload bytes. Four wires reach it: a serial clock, one bidirectional data line (seen here as separate in, out and output-enable signals for an external pad), and two active-low selects. The register select opens an addressed access. The first byte carries a read/write flag in bit 7 and a 7-bit register address in bits 6:0. One data byte follows. The FIFO select has no address phase. Every eight bits shifted in under it become one byte pushed to the transmit FIFO, and a single select window may carry any number of bytes.

All pins are passed through a two-stage synchroniser into the system clock domain. Edges of the serial clock are then detected there. Data is taken on rising serial-clock edges and launched on falling ones, most significant bit first. The system clock must run at least ten times faster than the serial clock, which is limited to 5 MHz. A small internal register file holds the configuration. An upper group of it is write-protected while the device reports that it is asleep.

Top module: `txspi_port`

## Requirements
- R1: Under the register select, a first byte with bit 7 = 0 and address A in bits 6:0, followed by byte D (both sent MSB first), stores D in register A.
- R2: Under the register select, a first byte with bit 7 = 1 and address A makes the port return the content of register A on `spi_sdio_out`, MSB first, one bit per serial clock, during the next eight clocks. Each bit is valid before the rising serial-clock edge.
- R3: `spi_sdio_oe` is 0 during the address byte and during any FIFO access. It is 1 from the first falling serial-clock edge after the address byte of a read. It returns to 0 within four system clocks after the register select is released.
- R4: Under the FIFO select, each complete group of eight bits produces a one-cycle `fifo_push` pulse, with the byte (first bit in bit 7) on `fifo_byte`. Several bytes may follow under one select, and no register is written.
- R5: Releasing either select before a byte is complete discards the partial bits. The next access starts again at bit 7.
- R6: While both selects are asserted, and until both are released, no register is written, no FIFO push occurs and `spi_sdio_oe` stays 0.
- R7: While `sleep_mode` is 1, writes to registers LOCK_BASE..NREGS-1 (defaults 12..15) are refused, and writes to lower registers proceed.
- R8: Writes to addresses at or above NREGS (default 16) are ignored, and reads of them return 0x00.
- R9: After reset all registers read 0x00, and `fifo_push`, `spi_sdio_oe` and `spi_sdio_out` are 0.
- R10: Serial clocks after the data byte of a register access, within the same select window, do not cause a second write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_reg_cs_n | input | 1 | Active-low select for register access |
| spi_fifo_cs_n | input | 1 | Active-low select for FIFO streaming |
| spi_sdio_in | input | 1 | Data line as seen from the pad input |
| spi_sdio_out | output | 1 | Read data towards the pad driver |
| spi_sdio_oe | output | 1 | Pad driver enable for the data line |
| sleep_mode | input | 1 | High while the device is asleep; locks the upper register group |
| fifo_push | output | 1 | One-cycle write strobe to the transmit FIFO |
| fifo_byte | output | 8 | Byte accompanying `fifo_push` |

## Verification
A corrupted bit counter or phase shows up at the ports within one byte time. A byte is then pushed one bit early or late, or a write lands at a shifted address, and the next read of that register returns a wrong value. A stuck output-enable or a stale read shift register appears on the data line during the very next read, or after release of the select. The bench therefore reads back every register it touches and compares each pushed byte against the bytes it sent.

// File: rtl/txspi_pkg.sv
package txspi_pkg;
  typedef enum logic [1:0] {
    PH_ADDR = 2'd0,
    PH_DATA = 2'd1,
    PH_DONE = 2'd2
  } phase_e;
endpackage

// File: rtl/txspi_sync.sv
module txspi_sync #(
  parameter int          W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/txspi_regfile.sv
module txspi_regfile #(
  parameter int NREGS     = 16,
  parameter int LOCK_BASE = 12,
  parameter int AW        = 7,
  parameter int DW        = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          sleep_mode,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int            IW     = (NREGS > 1) ? $clog2(NREGS) : 1;
  localparam logic [AW-1:0] TOP_A  = AW'(NREGS);
  localparam logic [AW-1:0] LOCK_A = AW'(LOCK_BASE);

  logic [DW-1:0] mem [NREGS];

  logic w_in_range, w_locked;
  assign w_in_range = (waddr < TOP_A);
  assign w_locked   = sleep_mode && (waddr >= LOCK_A);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) mem[i] <= '0;
      rdata <= '0;
    end else begin
      if (we && w_in_range && !w_locked) mem[waddr[IW-1:0]] <= wdata;
      rdata <= (raddr < TOP_A) ? mem[raddr[IW-1:0]] : '0;
    end
  end
endmodule

// File: rtl/txspi_frame.sv
module txspi_frame
  import txspi_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = DW - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk_s,
  input  logic          reg_cs_n_s,
  input  logic          fifo_cs_n_s,
  input  logic          sdi_s,
  output logic          reg_we,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  input  logic [DW-1:0] reg_rdata,
  output logic          sdo,
  output logic          sdo_oe,
  output logic          fifo_push,
  output logic [DW-1:0] fifo_byte
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic          sclk_d, spoiled, rd_flag;
  logic [CW-1:0] bit_cnt;
  logic [DW-1:0] in_sr, out_sr;
  logic [1:0]    load_pipe;
  phase_e        phase;

  logic rise, fall, reg_on, fifo_on, clash, idle, reg_go, fifo_go, byte_end;
  logic [DW-1:0] byte_now;

  assign rise     = sclk_s & ~sclk_d;
  assign fall     = ~sclk_s & sclk_d;
  assign reg_on   = ~reg_cs_n_s;
  assign fifo_on  = ~fifo_cs_n_s;
  assign clash    = reg_on & fifo_on;
  assign idle     = ~reg_on & ~fifo_on;
  assign reg_go   = reg_on & ~fifo_on & ~spoiled;
  assign fifo_go  = fifo_on & ~reg_on & ~spoiled;
  assign byte_now = {in_sr[DW-2:0], sdi_s};
  assign byte_end = rise && (bit_cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d    <= 1'b0;
      spoiled   <= 1'b0;
      rd_flag   <= 1'b0;
      bit_cnt   <= '0;
      in_sr     <= '0;
      out_sr    <= '0;
      load_pipe <= '0;
      phase     <= PH_ADDR;
      reg_we    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      sdo       <= 1'b0;
      sdo_oe    <= 1'b0;
      fifo_push <= 1'b0;
      fifo_byte <= '0;
    end else begin
      sclk_d    <= sclk_s;
      reg_we    <= 1'b0;
      fifo_push <= 1'b0;
      load_pipe <= {load_pipe[0], 1'b0};
      if (clash)     spoiled <= 1'b1;
      else if (idle) spoiled <= 1'b0;

      if (!reg_go && !fifo_go) begin
        bit_cnt <= '0;
        phase   <= PH_ADDR;
        rd_flag <= 1'b0;
        sdo_oe  <= 1'b0;
      end else begin
        if (rise) begin
          in_sr   <= byte_now;
          bit_cnt <= byte_end ? '0 : bit_cnt + CW'(1);
        end
        if (fifo_go && byte_end) begin
          fifo_push <= 1'b1;
          fifo_byte <= byte_now;
        end
        if (reg_go) begin
          if (byte_end && phase == PH_ADDR) begin
            rd_flag      <= byte_now[DW-1];
            reg_addr     <= byte_now[AW-1:0];
            load_pipe[0] <= byte_now[DW-1];
            phase        <= PH_DATA;
          end
          if (byte_end && phase == PH_DATA) begin
            phase <= PH_DONE;
            if (!rd_flag) begin
              reg_we    <= 1'b1;
              reg_wdata <= byte_now;
            end
          end
          if (load_pipe[1]) out_sr <= reg_rdata;
          if (fall && phase == PH_DATA && rd_flag) begin
            sdo    <= out_sr[DW-1];
            out_sr <= {out_sr[DW-2:0], 1'b0};
            sdo_oe <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/txspi_port.sv
module txspi_port #(
  parameter int NREGS     = 16,
  parameter int LOCK_BASE = 12,
  parameter int DW        = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          spi_sclk,
  input  logic          spi_reg_cs_n,
  input  logic          spi_fifo_cs_n,
  input  logic          spi_sdio_in,
  output logic          spi_sdio_out,
  output logic          spi_sdio_oe,
  input  logic          sleep_mode,
  output logic          fifo_push,
  output logic [DW-1:0] fifo_byte
);
  localparam int AW = DW - 1;

  logic          sclk_s, reg_cs_n_s, fifo_cs_n_s, sdi_s;
  logic          reg_we;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;

  txspi_sync #(.W(4), .RST_VAL(4'b0110)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({spi_sclk, spi_reg_cs_n, spi_fifo_cs_n, spi_sdio_in}),
    .q   ({sclk_s, reg_cs_n_s, fifo_cs_n_s, sdi_s})
  );

  txspi_frame #(.DW(DW), .AW(AW)) u_frame (
    .clk         (clk),
    .rst         (rst),
    .sclk_s      (sclk_s),
    .reg_cs_n_s  (reg_cs_n_s),
    .fifo_cs_n_s (fifo_cs_n_s),
    .sdi_s       (sdi_s),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .sdo         (spi_sdio_out),
    .sdo_oe      (spi_sdio_oe),
    .fifo_push   (fifo_push),
    .fifo_byte   (fifo_byte)
  );

  txspi_regfile #(.NREGS(NREGS), .LOCK_BASE(LOCK_BASE), .AW(AW), .DW(DW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .we         (reg_we),
    .waddr      (reg_addr),
    .wdata      (reg_wdata),
    .sleep_mode (sleep_mode),
    .raddr      (reg_addr),
    .rdata      (reg_rdata)
  );
endmodule

// File: rtl/txspi_port_chk.sv
module txspi_port_chk (
  input logic clk,
  input logic rst,
  input logic reg_cs_n_s,
  input logic fifo_cs_n_s,
  input logic reg_we,
  input logic fifo_push,
  input logic sdio_oe
);
  // R3: driver released one cycle after the synchronised register select goes high
  p_oe_release_r3: assert property (@(posedge clk) disable iff (rst)
    reg_cs_n_s |=> !sdio_oe);

  // R3: no driving while the FIFO select is active
  p_oe_not_fifo_r3: assert property (@(posedge clk) disable iff (rst)
    !fifo_cs_n_s |=> !sdio_oe);

  // R4: push is a single-cycle pulse
  p_push_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    fifo_push |=> !fifo_push);

  // R4: push only follows a cycle with FIFO select alone
  p_push_src_r4: assert property (@(posedge clk) disable iff (rst)
    fifo_push |-> $past(!fifo_cs_n_s && reg_cs_n_s));

  // R4: FIFO streaming never writes a register
  p_no_we_fifo_r4: assert property (@(posedge clk) disable iff (rst)
    $past(!fifo_cs_n_s) |-> !reg_we);

  // R6: both selects active means no action
  p_clash_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    $past(!reg_cs_n_s && !fifo_cs_n_s) |-> !(reg_we || fifo_push));
endmodule

bind txspi_port txspi_port_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_cs_n_s  (reg_cs_n_s),
  .fifo_cs_n_s (fifo_cs_n_s),
  .reg_we      (reg_we),
  .fifo_push   (fifo_push),
  .sdio_oe     (spi_sdio_oe)
);

// File: tb/tb_txspi_port.sv
`timescale 1ns/1ps
module tb_txspi_port;
  localparam int HALF  = 16;
  localparam int NREGS = 16;
  localparam int LOCK  = 12;

  logic clk = 1'b0, rst = 1'b1;
  always #2 clk = ~clk;

  logic sclk = 1'b0, csr_n = 1'b1, csf_n = 1'b1, sdi = 1'b0, sleep = 1'b0;
  wire        sdo, oe, fwr;
  wire [7:0]  fdat;

  txspi_port dut (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_reg_cs_n(csr_n),
    .spi_fifo_cs_n(csf_n), .spi_sdio_in(sdi), .spi_sdio_out(sdo),
    .spi_sdio_oe(oe), .sleep_mode(sleep), .fifo_push(fwr), .fifo_byte(fdat)
  );

  int checks = 0, fails = 0, ncap = 0, nwe_seen = 0;
  logic [7:0] model [NREGS];
  logic [7:0] cap [256];
  logic [7:0] tx [8];
  bit done = 0;

  always @(negedge clk) if (!rst && fwr) begin
    cap[ncap % 256] = fdat;
    ncap++;
  end

  function automatic bit lands(int a, bit slp);
    return (a < NREGS) && !(slp && a >= LOCK);
  endfunction

  function automatic logic [7:0] exp_rd(int a);
    return (a < NREGS) ? model[a] : 8'h00;
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_bits(input logic [7:0] b, input int nb, output logic [7:0] r,
                           output bit oe_all, output bit oe_any);
    oe_all = 1; oe_any = 0; r = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      sdi = b[i];
      wclk(HALF);
      r[i] = sdo;
      oe_all &= oe;
      oe_any |= oe;
      sclk = 1'b1;
      wclk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic reg_write(int a, logic [7:0] d);
    logic [7:0] r; bit al, an;
    csr_n = 1'b0; wclk(HALF);
    host_bits({1'b0, 7'(a)}, 8, r, al, an);
    host_bits(d, 8, r, al, an);
    wclk(HALF); csr_n = 1'b1; wclk(2 * HALF);
    if (lands(a, sleep)) model[a] = d;
  endtask

  task automatic reg_read(int a, string tag, output logic [7:0] r);
    bit al, an, dal, dan;
    csr_n = 1'b0; wclk(HALF);
    host_bits({1'b1, 7'(a)}, 8, r, al, an);
    chk("R3 oe during address", {31'b0, an}, 0);
    host_bits(8'h00, 8, r, dal, dan);
    chk("R3 oe during data", {31'b0, dal}, 1);
    wclk(HALF); csr_n = 1'b1; wclk(6);
    chk("R3 oe after release", {31'b0, oe}, 0);
    wclk(2 * HALF);
    chk(tag, {24'b0, r}, {24'b0, exp_rd(a)});
  endtask

  task automatic fifo_send(int n, string tag);
    logic [7:0] r; bit al, an, any_oe;
    int base;
    base = ncap; any_oe = 0;
    csf_n = 1'b0; wclk(HALF);
    for (int k = 0; k < n; k++) begin
      host_bits(tx[k], 8, r, al, an);
      any_oe |= an;
    end
    wclk(HALF); csf_n = 1'b1; wclk(2 * HALF);
    chk("R3 oe in fifo mode", {31'b0, any_oe}, 0);
    chk({tag, " count"}, ncap - base, n);
    for (int k = 0; k < n; k++)
      chk({tag, " byte"}, {24'b0, cap[(base + k) % 256]}, {24'b0, tx[k]});
  endtask

  initial begin
    logic [7:0] r; bit al, an;
    int base;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < NREGS; i++) model[i] = 8'h00;
    wclk(5); rst = 1'b0; wclk(5);

    // R9 reset state
    chk("R9 push", {31'b0, fwr}, 0);
    chk("R9 oe", {31'b0, oe}, 0);
    chk("R9 sdo", {31'b0, sdo}, 0);
    reg_read(0, "R9 reg0", r);
    reg_read(13, "R9 reg13", r);

    // R1 / R2 directed
    reg_write(5, 8'hA5);
    reg_read(5, "R1 R2 write/read reg5", r);
    reg_write(0, 8'h81);
    reg_read(0, "R2 reg0 msb/lsb", r);

    // R7 sleep lock
    sleep = 1'b1;
    reg_write(13, 8'h5A);
    reg_write(4, 8'h3C);
    sleep = 1'b0;
    reg_read(13, "R7 locked reg13", r);
    reg_read(4, "R7 unlocked reg4", r);
    reg_write(15, 8'hE7);
    reg_read(15, "R7 awake reg15", r);

    // R8 out of range
    reg_write(80, 8'h77);
    reg_read(80, "R8 read out of range", r);
    reg_read(0, "R8 reg0 untouched", r);

    // R4 multi-byte burst
    tx[0] = 8'h01; tx[1] = 8'hFE; tx[2] = 8'h96;
    fifo_send(3, "R4 burst");

    // R5 partial FIFO byte discarded
    base = ncap;
    csf_n = 1'b0; wclk(HALF);
    host_bits(8'hFF, 5, r, al, an);
    wclk(HALF); csf_n = 1'b1; wclk(2 * HALF);
    chk("R5 no push on partial", ncap - base, 0);
    tx[0] = 8'h3C;
    fifo_send(1, "R5 fresh byte");

    // R5 partial register frame discarded
    csr_n = 1'b0; wclk(HALF);
    host_bits(8'h07, 4, r, al, an);
    wclk(HALF); csr_n = 1'b1; wclk(2 * HALF);
    reg_write(6, 8'h42);
    reg_read(6, "R5 register after partial", r);

    // R10 extra clocks after data byte
    csr_n = 1'b0; wclk(HALF);
    host_bits(8'h07, 8, r, al, an);
    host_bits(8'h11, 8, r, al, an);
    host_bits(8'hEE, 8, r, al, an);
    wclk(HALF); csr_n = 1'b1; wclk(2 * HALF);
    model[7] = 8'h11;
    reg_read(7, "R10 no second write", r);

    // R6 clash
    base = ncap;
    csr_n = 1'b0; csf_n = 1'b0; wclk(HALF);
    host_bits(8'h03, 8, r, al, an);
    host_bits(8'hAA, 8, r, al, an);
    chk("R6 oe during clash", {31'b0, an}, 0);
    csf_n = 1'b1; wclk(HALF);
    host_bits(8'h55, 8, r, al, an);
    wclk(HALF); csr_n = 1'b1; wclk(2 * HALF);
    chk("R6 no push", ncap - base, 0);
    reg_read(3, "R6 reg3 unchanged", r);

    // random mix
    for (int it = 0; it < 40; it++) begin
      int op, a, n;
      op = $urandom % 3;
      a  = $urandom % 20;
      if (op == 0) begin
        sleep = $urandom % 2;
        reg_write(a, 8'($urandom));
        sleep = 1'b0;
      end else if (op == 1) begin
        reg_read(a, "R1 R2 R7 R8 random read", r);
      end else begin
        n = 1 + $urandom % 4;
        for (int k = 0; k < n; k++) tx[k] = 8'($urandom);
        fifo_send(n, "R4 random burst");
      end
    end
    for (int a = 0; a < NREGS; a++) reg_read(a, "R1 R7 final sweep", r);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule